// File: doc/BRIEF.md
# DMA Channel Trigger Gate

This block sits beside the transfer engine of one DMA channel and holds back chosen transfer steps until an external trigger event has been seen. It picks one of a parameterised set of trigger lines, resynchronises it, and looks for a rising or a falling edge on it. Each edge found is a "hit". At most one hit is kept in reserve. A hit found while a hit is already in reserve and a triggered step is still running is thrown away and raises a sticky overrun flag. The block can also raise an interrupt for it.

The engine presents each step it wants to start as a request, tagged with a kind: first read of a block, any other single read, or a linked-list link load. A programmed mode decides which kinds need a hit. A request is granted in the same cycle when it needs no hit, or when a hit is in reserve. Granting a gated request uses up the hit and marks a triggered step as running. The step stays running until the engine reports it done. Configuration is captured on a load strobe. Turning the channel enable off drops everything held.

Top module: `dma_trig_gate`

## Requirements
- R1: With polarity code 2'b00 or 2'b11, or with the channel enable low, no step is gated. While enabled, `xfer_grant` equals `xfer_req` in the same cycle for every kind and mode.
- R2: Polarity 2'b01 makes a 0-to-1 change on the selected line a hit. Polarity 2'b10 makes a 1-to-0 change a hit. The other direction of change does nothing. A line change reaches the reserve three rising clock edges after it is applied, through a two-flop synchroniser and the reserve register.
- R3: In modes 2'b00 and 2'b01, only kind 2'd0 (first read of a block) needs a hit. Kinds 2'd1 (other single read) and 2'd2 (link load) pass at once.
- R4: In mode 2'b10, only kind 2'd2 needs a hit. Both read kinds pass at once.
- R5: In mode 2'b11, kinds 2'd0 and 2'd1 each need a hit. Kind 2'd2 passes at once.
- R6: Granting a gated request uses up the hit, and a later gated request waits for a new hit. One hit found while the triggered step is running is kept. It grants the next gated request without a further edge.
- R7: A hit found while a hit is in reserve and a triggered step is still running is discarded, and `ovr_flag` is set. `ovr_irq` equals `ovr_flag` AND `ovr_ie`. The channel keeps granting.
- R8: `ovr_flag` is 0 after reset. Once set, it stays set until an `ovr_clr` pulse. If a new overrun happens in the same cycle as the clear, the set wins.
- R9: A `cfg_load` that changes the trigger select or the polarity discards the hit in reserve and restarts edge detection. A hit in that same cycle is also discarded. A load that changes only the mode keeps the hit.
- R10: Low `ch_en` discards the hit, ends the running step and ignores edges. A line already at its active level when the channel is enabled gives no hit.
- R11: Only the line chosen by `cfg_sel` can produce a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | N_TRIG | Asynchronous trigger lines |
| ch_en | input | 1 | Channel enable |
| cfg_load | input | 1 | Strobe that captures cfg_sel, cfg_pol and cfg_mode |
| cfg_sel | input | SEL_W | Trigger line index |
| cfg_pol | input | 2 | Edge polarity code |
| cfg_mode | input | 2 | Gating granularity code |
| ovr_ie | input | 1 | Overrun interrupt enable |
| ovr_clr | input | 1 | Clear pulse for the overrun flag |
| xfer_req | input | 1 | Engine wants to start a step |
| xfer_kind | input | 2 | Kind of step: 0 first read, 1 other read, 2 link load |
| xfer_done | input | 1 | Running triggered step has finished |
| xfer_grant | output | 1 | Step may start this cycle |
| ovr_flag | output | 1 | Sticky trigger overrun flag |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
Each mode is tried with all three request kinds, with and without a hit in reserve. This separates the kinds that are gated from those that pass through. Rising and falling edges are applied under both active polarities, and edges are placed on lines other than the selected one, so edge direction and line choice are each shown to matter. Hit sequences of one, two and three edges during a running step separate a hit that is kept from one that overruns. Config loads that change the select versus only the mode, and a disable followed by an enable with the line held high, show when the reserve is discarded.

// File: rtl/dtg_pkg.sv
// Shared codes for the DMA channel trigger gate.
package dtg_pkg;
    typedef enum logic [1:0] {
        XK_FIRST  = 2'd0,
        XK_SINGLE = 2'd1,
        XK_LINK   = 2'd2
    } xfer_kind_t;

    localparam logic [1:0] POL_RISE = 2'b01;
    localparam logic [1:0] POL_FALL = 2'b10;

    localparam logic [1:0] MODE_LINK   = 2'b10;
    localparam logic [1:0] MODE_SINGLE = 2'b11;
endpackage

// File: rtl/dtg_sync.sv
// Two-flop synchroniser for every trigger line.
// Assumes the lines are asynchronous levels that are wider than two clocks.
module dtg_sync #(
    parameter int N_TRIG = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] async_in,
    output logic [N_TRIG-1:0] sync_out
);
    generate
        for (genvar i = 0; i < N_TRIG; i++) begin : g_line
            logic meta_q;
            logic stab_q;
            // Two-stage capture of one line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= async_in[i];
                    stab_q <= meta_q;
                end
            end
            assign sync_out[i] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/dtg_edge.sv
// Holds the trigger configuration, selects one synchronised line and finds
// edges on it. It reports a hit only after a clean cycle of monitoring.
// Assumes cfg_* are stable while cfg_load is high.
module dtg_edge
    import dtg_pkg::*;
#(
    parameter int N_TRIG = 32,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] line_s,
    input  logic              ch_en,
    input  logic              cfg_load,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [1:0]        cfg_pol,
    input  logic [1:0]        cfg_mode,
    output logic [1:0]        mode_q,
    output logic              active,
    output logic              cfg_change,
    output logic              hit
);
    logic [SEL_W-1:0] sel_q;
    logic [1:0]       pol_q;
    logic             prev_q;
    logic             armed_q;
    logic             cur;

    // Capture the configuration on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            pol_q  <= 2'b00;
            mode_q <= 2'b00;
        end else if (cfg_load) begin
            sel_q  <= cfg_sel;
            pol_q  <= cfg_pol;
            mode_q <= cfg_mode;
        end
    end

    assign cur        = line_s[sel_q];
    assign active     = ch_en && (pol_q == POL_RISE || pol_q == POL_FALL);
    assign cfg_change = cfg_load && (cfg_sel != sel_q || cfg_pol != pol_q);

    // Track the previous sample and arm after one clean monitoring cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= cur;
            armed_q <= active && !cfg_change;
        end
    end

    // Detect the chosen edge.
    always_comb begin
        hit = 1'b0;
        if (armed_q && active && !cfg_change) begin
            if (pol_q == POL_RISE) hit = cur && !prev_q;
            else                   hit = !cur && prev_q;
        end
    end
endmodule

// File: rtl/dtg_need.sv
// Decides if the requested step kind must wait for a hit in the current mode.
// Assumes the kind code is one of the three defined in dtg_pkg.
module dtg_need
    import dtg_pkg::*;
(
    input  logic       active,
    input  logic [1:0] mode,
    input  logic [1:0] kind,
    output logic       needs_hit
);
    // Map mode and kind onto a gating decision.
    always_comb begin
        needs_hit = 1'b0;
        if (active) begin
            case (mode)
                MODE_LINK:   needs_hit = (kind == XK_LINK);
                MODE_SINGLE: needs_hit = (kind == XK_FIRST) || (kind == XK_SINGLE);
                default:     needs_hit = (kind == XK_FIRST);
            endcase
        end
    end
endmodule

// File: rtl/dtg_ctrl.sv
// Keeps the single hit reserve and the running-step marker, grants requests
// and raises the sticky overrun flag.
// Assumes xfer_done only follows a granted gated step.
module dtg_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ch_en,
    input  logic cfg_change,
    input  logic hit,
    input  logic req,
    input  logic needs_hit,
    input  logic done,
    input  logic ovr_clr,
    output logic grant,
    output logic pend_q,
    output logic ovr_q
);
    logic busy_q;
    logic consume;
    logic overrun;

    assign grant   = ch_en && req && (!needs_hit || pend_q);
    assign consume = grant && needs_hit;
    assign overrun = hit && pend_q && busy_q && !consume;

    // Hit reserve: filled by a hit, emptied by use, config change or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !ch_en || cfg_change) pend_q <= 1'b0;
        else if (hit && (!pend_q || consume)) pend_q <= 1'b1;
        else if (consume) pend_q <= 1'b0;
    end

    // Running triggered step marker.
    always_ff @(posedge clk) begin
        if (!rst_n || !ch_en) busy_q <= 1'b0;
        else if (consume) busy_q <= 1'b1;
        else if (done) busy_q <= 1'b0;
    end

    // Sticky overrun flag; a new overrun beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else if (overrun) ovr_q <= 1'b1;
        else if (ovr_clr) ovr_q <= 1'b0;
    end

    // R7: the flag only rises after a hit met a full reserve and a running step.
    a_r7_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(pend_q && busy_q && hit));

    // R8: the flag holds without a clear.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !ovr_clr) |=> ovr_q);

    // R10: disable empties reserve and running marker.
    a_r10_disable_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> (!pend_q && !busy_q));
endmodule

// File: rtl/dma_trig_gate.sv
// DMA channel trigger gate: conditions engine steps on edges of a selected
// trigger line. Assumes one engine request at a time and that N_TRIG is a
// power of two.
module dma_trig_gate #(
    parameter int N_TRIG = 32,
    localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic              ch_en,
    input  logic              cfg_load,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [1:0]        cfg_pol,
    input  logic [1:0]        cfg_mode,
    input  logic              ovr_ie,
    input  logic              ovr_clr,
    input  logic              xfer_req,
    input  logic [1:0]        xfer_kind,
    input  logic              xfer_done,
    output logic              xfer_grant,
    output logic              ovr_flag,
    output logic              ovr_irq
);
    logic [N_TRIG-1:0] line_s;
    logic [1:0]        mode_q;
    logic              active;
    logic              cfg_change;
    logic              hit;
    logic              needs_hit;
    logic              pend_q;

    dtg_sync #(.N_TRIG(N_TRIG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(trig_in), .sync_out(line_s)
    );

    dtg_edge #(.N_TRIG(N_TRIG), .SEL_W(SEL_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .line_s(line_s), .ch_en(ch_en),
        .cfg_load(cfg_load), .cfg_sel(cfg_sel), .cfg_pol(cfg_pol),
        .cfg_mode(cfg_mode), .mode_q(mode_q), .active(active),
        .cfg_change(cfg_change), .hit(hit)
    );

    dtg_need u_need (
        .active(active), .mode(mode_q), .kind(xfer_kind), .needs_hit(needs_hit)
    );

    dtg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .cfg_change(cfg_change),
        .hit(hit), .req(xfer_req), .needs_hit(needs_hit), .done(xfer_done),
        .ovr_clr(ovr_clr), .grant(xfer_grant), .pend_q(pend_q), .ovr_q(ovr_flag)
    );

    assign ovr_irq = ovr_flag && ovr_ie;

    // R1: with no active trigger, grants follow requests.
    a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && !active) |-> (xfer_grant == xfer_req));

    // R9: a select or polarity change leaves the reserve empty.
    a_r9_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> !pend_q);
endmodule

// File: tb/dma_trig_gate_tb.sv
module dma_trig_gate_tb;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] trig_in = '0;
    logic        ch_en = 1'b0;
    logic        cfg_load = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [1:0]  cfg_pol = '0;
    logic [1:0]  cfg_mode = '0;
    logic        ovr_ie = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        xfer_req = 1'b0;
    logic [1:0]  xfer_kind = '0;
    logic        xfer_done = 1'b0;
    logic        xfer_grant;
    logic        ovr_flag;
    logic        ovr_irq;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dma_trig_gate #(.N_TRIG(N)) u_dut (.*);

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input int sel, input logic [1:0] pol, input logic [1:0] mode);
        @(negedge clk);
        cfg_sel = sel[4:0]; cfg_pol = pol; cfg_mode = mode; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        idle(3);
    endtask

    task automatic set_line(input int idx, input logic v);
        @(negedge clk);
        trig_in[idx] = v;
        idle(4);
    endtask

    task automatic pulse(input int idx);
        set_line(idx, 1'b1);
        set_line(idx, 1'b0);
    endtask

    // Present one request; check the same-cycle grant, then release.
    task automatic try_req(input logic [1:0] kind, input logic exp, input string tag);
        @(negedge clk);
        xfer_req = 1'b1; xfer_kind = kind;
        #1;
        check(xfer_grant, exp, tag);
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check(xfer_grant, 1'b0, "R8 reset grant");
        check(ovr_flag, 1'b0, "R8 reset flag");
        check(ovr_irq, 1'b0, "R8 reset irq");
    endtask

    task automatic t_no_trigger();
        load(5, 2'b00, 2'b11);
        try_req(2'd0, 1'b1, "R1 pol00 first");
        try_req(2'd1, 1'b1, "R1 pol00 single");
        load(5, 2'b11, 2'b10);
        try_req(2'd2, 1'b1, "R1 pol11 link");
    endtask

    task automatic t_block_mode();
        load(5, 2'b01, 2'b00);
        try_req(2'd0, 1'b0, "R3 first waits");
        try_req(2'd1, 1'b1, "R3 single free");
        try_req(2'd2, 1'b1, "R3 link free");
        pulse(5);
        try_req(2'd0, 1'b1, "R3 first after hit");
        done_pulse();
        try_req(2'd0, 1'b0, "R6 hit used up");
        pulse(5);
        load(5, 2'b01, 2'b01);
        try_req(2'd0, 1'b1, "R9 mode-only load keeps hit, R3 mode01");
        done_pulse();
    endtask

    task automatic t_falling();
        load(5, 2'b10, 2'b11);
        set_line(5, 1'b1);
        try_req(2'd1, 1'b0, "R2 rise ignored under fall");
        set_line(5, 1'b0);
        try_req(2'd1, 1'b1, "R2 fall is hit");
        done_pulse();
    endtask

    task automatic t_link_mode();
        load(5, 2'b01, 2'b10);
        try_req(2'd0, 1'b1, "R4 first free");
        try_req(2'd1, 1'b1, "R4 single free");
        try_req(2'd2, 1'b0, "R4 link waits");
        pulse(5);
        try_req(2'd2, 1'b1, "R4 link after hit");
        done_pulse();
    endtask

    task automatic t_select();
        load(7, 2'b01, 2'b11);
        try_req(2'd2, 1'b1, "R5 link free");
        pulse(3);
        try_req(2'd1, 1'b0, "R11 other line ignored");
        pulse(7);
        try_req(2'd1, 1'b1, "R11 selected line");
        done_pulse();
        pulse(7);
        try_req(2'd0, 1'b1, "R5 first gated granted");
    endtask

    task automatic t_overrun();
        ovr_ie = 1'b1;
        pulse(7);
        check(ovr_flag, 1'b0, "R6 one stored hit no overrun");
        pulse(7);
        check(ovr_flag, 1'b1, "R7 flag set");
        check(ovr_irq, 1'b1, "R7 irq");
        try_req(2'd1, 1'b1, "R6 stored hit grants");
        done_pulse();
        try_req(2'd1, 1'b0, "R7 extra hit lost");
    endtask

    task automatic t_clear();
        idle(5);
        check(ovr_flag, 1'b1, "R8 sticky");
        ovr_ie = 1'b0;
        #1;
        check(ovr_irq, 1'b0, "R7 irq masked");
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        check(ovr_flag, 1'b0, "R8 cleared");
    endtask

    task automatic t_change();
        pulse(7);
        load(8, 2'b01, 2'b11);
        try_req(2'd1, 1'b0, "R9 select change drops hit");
        pulse(8);
        try_req(2'd1, 1'b1, "R9 new line works");
        done_pulse();
    endtask

    task automatic t_disable();
        pulse(8);
        @(negedge clk); ch_en = 1'b0;
        idle(2);
        @(negedge clk); ch_en = 1'b1;
        idle(2);
        try_req(2'd1, 1'b0, "R10 disable drops hit");
        @(negedge clk); ch_en = 1'b0;
        set_line(8, 1'b1);
        @(negedge clk); ch_en = 1'b1;
        idle(4);
        try_req(2'd1, 1'b0, "R10 level at enable no hit");
        set_line(8, 1'b0);
        set_line(8, 1'b1);
        try_req(2'd1, 1'b1, "R10 edge after enable");
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        ch_en = 1'b1;
        t_no_trigger();
        t_block_mode();
        t_falling();
        t_link_mode();
        t_select();
        t_overrun();
        t_clear();
        t_change();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule